// File: doc/BRIEF.md
# SMBus Host Controller Register File

This block is the byte-wide register front end of an SMBus host controller. Software reaches it through a small register bus with a byte offset, write data, read data and separate read and write strobes. It holds a status register, a control register, a command byte, a target-address byte, two data bytes and a 32-entry block buffer reached through a single auto-advancing data port.

The block decodes the protocol type, the read/write direction and the 7-bit target address, and hands them to a separate transaction sequencer along with a one-clock start pulse. When the sequencer reports completion, the block records success or the kind of error, captures any returned data bytes, and drops the busy flag. The sequencer also has a direct port into the block buffer. The interrupt status bit drives a level output.

Top module: `smbus_host_regs`

## Requirements
- R1: After reset every register, every block buffer entry and the buffer index are zero, `irq` is low and `seq_start` is low.
- R2: Offsets other than 0x00 and 0x02 to 0x07 read as zero, and writes to them change no register.
- R3: Writing the status register (offset 0x00) clears each status bit written as 1, leaves the others unchanged and returns the buffer index to 0. Bit map: 0 busy, 1 interrupt, 2 device error, 3 bus error, 4 failed, 5 alert, 6 in-use, 7 byte done. Bits 5 and 6 are set by one-clock pulses on `alert_evt` and `claim_evt`.
- R4: A write to control (offset 0x02) stores the byte. If bit 6 of the written byte is 1, the busy bit is set at that edge, and `seq_start` is high for exactly the next clock cycle.
- R5: Reading control returns the stored bits 4:0 with bits 7:5 as zero, and returns the buffer index to 0.
- R6: `seq_proto` equals control bits 4:2. `seq_read` equals target-address bit 0. `seq_target` equals target-address bits 7:1.
- R7: Each read or write of block data (offset 0x07) accesses the buffer entry at the index, and the index then advances by one. After entry 31 it returns to 0.
- R8: A `seq_done` pulse clears busy. If none of `seq_dev_err`, `seq_bus_err` or `seq_failed` is set, it sets byte done (bit 7) and interrupt (bit 1). Otherwise it sets the matching bits 2, 3 and 4 only. If a start write occurs in the same cycle, busy stays set.
- R9: On a successful `seq_done`, `seq_ld0` loads data0 from `seq_rdata[7:0]` and `seq_ld1` loads data1 from `seq_rdata[15:8]`. A failed completion loads nothing.
- R10: `irq` is high exactly while status bit 1 is set.
- R11: Command (0x03), target address (0x04), data0 (0x05) and data1 (0x06) read back the full byte last written. `seq_cmd`, `seq_data0` and `seq_data1` show these values.
- R12: `seq_buf_rdata` shows the buffer entry at `seq_buf_addr`. `seq_buf_we` writes `seq_buf_wdata` there, unless a host block-data write occurs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one byte |
| bus_rd | input | 1 | Read strobe, one byte |
| bus_rdata | output | 8 | Read data for the current offset |
| irq | output | 1 | Interrupt level |
| seq_start | output | 1 | One-clock transaction start |
| seq_proto | output | 3 | Protocol type |
| seq_read | output | 1 | Direction, 1 = read |
| seq_target | output | 7 | Target device address |
| seq_cmd | output | 8 | Command byte |
| seq_data0 | output | 8 | Data byte 0 |
| seq_data1 | output | 8 | Data byte 1 |
| seq_done | input | 1 | Transaction completion pulse |
| seq_dev_err | input | 1 | Completion with device error |
| seq_bus_err | input | 1 | Completion with bus error |
| seq_failed | input | 1 | Completion with failure |
| seq_ld0 | input | 1 | Load data0 on completion |
| seq_ld1 | input | 1 | Load data1 on completion |
| seq_rdata | input | 16 | Returned data word |
| seq_buf_addr | input | IDX_W | Sequencer buffer entry |
| seq_buf_we | input | 1 | Sequencer buffer write |
| seq_buf_wdata | input | 8 | Sequencer buffer write data |
| seq_buf_rdata | output | 8 | Sequencer buffer read data |
| alert_evt | input | 1 | Sets the alert status bit |
| claim_evt | input | 1 | Sets the in-use status bit |

## Verification
The bench builds the block with its defaults: ADDR_W = 6 and BUF_DEPTH = 32. With these values the whole 64-offset window can be swept, so every unmapped offset is visited. All 256 clear masks are applied to a fully set status register, and all 256 values are written to every byte register and to control. Twice the buffer depth of block accesses reaches the index wrap more than once. The pre-filled buffer also lets the bench check the sequencer-side port against a known image.

// File: rtl/smbus_host_regs.sv
module smbus_host_regs #(
  parameter int ADDR_W    = 6,
  parameter int BUF_DEPTH = 32,
  localparam int IDX_W    = $clog2(BUF_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [7:0]        bus_rdata,
  output logic              irq,
  output logic              seq_start,
  output logic [2:0]        seq_proto,
  output logic              seq_read,
  output logic [6:0]        seq_target,
  output logic [7:0]        seq_cmd,
  output logic [7:0]        seq_data0,
  output logic [7:0]        seq_data1,
  input  logic              seq_done,
  input  logic              seq_dev_err,
  input  logic              seq_bus_err,
  input  logic              seq_failed,
  input  logic              seq_ld0,
  input  logic              seq_ld1,
  input  logic [15:0]       seq_rdata,
  input  logic [IDX_W-1:0]  seq_buf_addr,
  input  logic              seq_buf_we,
  input  logic [7:0]        seq_buf_wdata,
  output logic [7:0]        seq_buf_rdata,
  input  logic              alert_evt,
  input  logic              claim_evt
);
  localparam logic [ADDR_W-1:0] OFF_STS = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_CTL = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] OFF_CMD = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] OFF_TGT = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFF_D0  = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] OFF_D1  = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] OFF_BLK = ADDR_W'(7);
  localparam logic [IDX_W-1:0]  IDX_LAST = IDX_W'(BUF_DEPTH - 1);

  logic [7:0] sts_q, ctl_q, cmd_q, tgt_q, d0_q, d1_q;
  logic [7:0] buf_q [BUF_DEPTH];
  logic [IDX_W-1:0] idx_q;
  logic start_q;

  wire rd_go  = bus_rd & ~bus_wr;
  wire wr_sts = bus_wr & (bus_addr == OFF_STS);
  wire wr_ctl = bus_wr & (bus_addr == OFF_CTL);
  wire rd_ctl = rd_go  & (bus_addr == OFF_CTL);
  wire wr_blk = bus_wr & (bus_addr == OFF_BLK);
  wire rd_blk = rd_go  & (bus_addr == OFF_BLK);
  wire start_req = wr_ctl & bus_wdata[6];
  wire seq_err = seq_dev_err | seq_bus_err | seq_failed;
  wire done_ok = seq_done & ~seq_err;

  wire [7:0] sts_set = {done_ok, claim_evt, alert_evt, seq_done & seq_failed,
                        seq_done & seq_bus_err, seq_done & seq_dev_err, done_ok, start_req};
  wire [7:0] sts_clr = (wr_sts ? bus_wdata : 8'h00) | {7'b0, seq_done};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_q   <= '0;
      ctl_q   <= '0;
      cmd_q   <= '0;
      tgt_q   <= '0;
      d0_q    <= '0;
      d1_q    <= '0;
      idx_q   <= '0;
      start_q <= 1'b0;
    end else begin
      sts_q   <= (sts_q & ~sts_clr) | sts_set;
      start_q <= start_req;
      if (wr_ctl) ctl_q <= bus_wdata;
      if (bus_wr && bus_addr == OFF_CMD) cmd_q <= bus_wdata;
      if (bus_wr && bus_addr == OFF_TGT) tgt_q <= bus_wdata;
      if (bus_wr && bus_addr == OFF_D0) d0_q <= bus_wdata;
      else if (done_ok && seq_ld0) d0_q <= seq_rdata[7:0];
      if (bus_wr && bus_addr == OFF_D1) d1_q <= bus_wdata;
      else if (done_ok && seq_ld1) d1_q <= seq_rdata[15:8];
      if (wr_sts || rd_ctl) idx_q <= '0;
      else if (wr_blk || rd_blk) idx_q <= (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < BUF_DEPTH; i++) buf_q[i] <= '0;
    end else if (wr_blk) begin
      buf_q[idx_q] <= bus_wdata;
    end else if (seq_buf_we) begin
      buf_q[seq_buf_addr] <= seq_buf_wdata;
    end
  end

  always_comb begin
    case (bus_addr)
      OFF_STS: bus_rdata = sts_q;
      OFF_CTL: bus_rdata = {3'b000, ctl_q[4:0]};
      OFF_CMD: bus_rdata = cmd_q;
      OFF_TGT: bus_rdata = tgt_q;
      OFF_D0:  bus_rdata = d0_q;
      OFF_D1:  bus_rdata = d1_q;
      OFF_BLK: bus_rdata = buf_q[idx_q];
      default: bus_rdata = 8'h00;
    endcase
  end

  assign irq           = sts_q[1];
  assign seq_start     = start_q;
  assign seq_proto     = ctl_q[4:2];
  assign seq_read      = tgt_q[0];
  assign seq_target    = tgt_q[7:1];
  assign seq_cmd       = cmd_q;
  assign seq_data0     = d0_q;
  assign seq_data1     = d1_q;
  assign seq_buf_rdata = buf_q[seq_buf_addr];

  // R4
  start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFF_CTL && bus_wdata[6]) |=> (seq_start && sts_q[0]));

  // R8
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_done && !start_req) |=> !sts_q[0]);

  // R8
  ok_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_done && !seq_dev_err && !seq_bus_err && !seq_failed) |=> (sts_q[7] && irq));

  // R7
  idx_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_blk || wr_blk) && idx_q == IDX_LAST) |=> (idx_q == '0));

  // R3
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sts && bus_wdata[1] && !seq_done) |=> !irq);

  // R5
  ctl_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ctl |=> (idx_q == '0));
endmodule

// File: tb/tb_smbus_host_regs.sv
module tb_smbus_host_regs;
  localparam int CLK_NS = 10;
  localparam int AW = 6;
  localparam int DEPTH = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic irq, seq_start, seq_read;
  logic [2:0] seq_proto;
  logic [6:0] seq_target;
  logic [7:0] seq_cmd, seq_data0, seq_data1, seq_buf_rdata;
  logic seq_done = 0, seq_dev_err = 0, seq_bus_err = 0, seq_failed = 0;
  logic seq_ld0 = 0, seq_ld1 = 0;
  logic [15:0] seq_rdata = '0;
  logic [4:0] seq_buf_addr = '0;
  logic seq_buf_we = 0;
  logic [7:0] seq_buf_wdata = '0;
  logic alert_evt = 0, claim_evt = 0;

  int checks = 0, errors = 0;
  logic [7:0] img [DEPTH];

  always #(CLK_NS/2) clk = ~clk;

  smbus_host_regs #(.ADDR_W(AW), .BUF_DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq),
    .seq_start(seq_start), .seq_proto(seq_proto), .seq_read(seq_read),
    .seq_target(seq_target), .seq_cmd(seq_cmd), .seq_data0(seq_data0),
    .seq_data1(seq_data1), .seq_done(seq_done), .seq_dev_err(seq_dev_err),
    .seq_bus_err(seq_bus_err), .seq_failed(seq_failed), .seq_ld0(seq_ld0),
    .seq_ld1(seq_ld1), .seq_rdata(seq_rdata), .seq_buf_addr(seq_buf_addr),
    .seq_buf_we(seq_buf_we), .seq_buf_wdata(seq_buf_wdata),
    .seq_buf_rdata(seq_buf_rdata), .alert_evt(alert_evt), .claim_evt(claim_evt));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    bus_addr = AW'(a); bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, input string tag, input logic [7:0] exp);
    bus_addr = AW'(a); bus_rd = 1'b1;
    #1 chk(tag, 16'(bus_rdata), 16'(exp));
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic done(input logic de, be, fl, l0, l1, input logic [15:0] rv);
    seq_done = 1; seq_dev_err = de; seq_bus_err = be; seq_failed = fl;
    seq_ld0 = l0; seq_ld1 = l1; seq_rdata = rv;
    @(posedge clk); @(negedge clk);
    seq_done = 0; seq_dev_err = 0; seq_bus_err = 0; seq_failed = 0; seq_ld0 = 0; seq_ld1 = 0;
  endtask

  task automatic fill_status();
    done(0, 0, 0, 0, 0, 16'h0);
    done(1, 1, 1, 0, 0, 16'h0);
    alert_evt = 1; claim_evt = 1;
    @(posedge clk); @(negedge clk);
    alert_evt = 0; claim_evt = 0;
    wr(2, 8'h40);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 8; a++) rd(a, "R1 reg", 8'h00);
    chk("R1 irq", 16'(irq), 16'h0);
    chk("R1 start", 16'(seq_start), 16'h0);
    chk("R1 buf", 16'(seq_buf_rdata), 16'h0);

    // R4 start pulse and busy
    wr(2, 8'h48);
    chk("R4 start high", 16'(seq_start), 16'h1);
    chk("R6 proto", 16'(seq_proto), 16'h2);
    rd(0, "R4 busy", 8'h01);
    chk("R4 start one clock", 16'(seq_start), 16'h0);
    // R8 success, R9 data0 only, R10 irq
    done(0, 0, 0, 1, 0, 16'h1234);
    rd(0, "R8 ok status", 8'h82);
    chk("R10 irq high", 16'(irq), 16'h1);
    rd(5, "R9 data0", 8'h34);
    rd(6, "R9 data1 untouched", 8'h00);
    done(0, 0, 0, 1, 1, 16'hBEEF);
    rd(5, "R9 data0 both", 8'hEF);
    rd(6, "R9 data1 both", 8'hBE);
    chk("R11 seq_data1", 16'(seq_data1), 16'hBE);
    wr(2, 8'h40);
    done(1, 0, 1, 1, 1, 16'h5555);
    rd(0, "R8 err status", 8'h96);
    rd(5, "R9 no load on error", 8'hEF);
    wr(0, 8'h02);
    chk("R10 irq low", 16'(irq), 16'h0);
    rd(0, "R3 partial clear", 8'h94);
    // R8 start in same cycle as done keeps busy
    wr(0, 8'hFF);
    bus_addr = 2; bus_wdata = 8'h40; bus_wr = 1; seq_done = 1;
    @(posedge clk); @(negedge clk);
    bus_wr = 0; seq_done = 0;
    rd(0, "R8 start wins over done", 8'h83);
    wr(0, 8'hFF);

    // R3 full clear-mask sweep
    for (int m = 0; m < 256; m++) begin
      fill_status();
      wr(0, 8'(m));
      rd(0, "R3 w1c sweep", 8'(~m));
      wr(0, 8'hFF);
    end

    // R5 and R6 control sweep
    for (int v = 0; v < 256; v++) begin
      wr(2, 8'(v));
      chk("R6 proto sweep", 16'(seq_proto), 16'((v >> 2) & 7));
      rd(2, "R5 ctl readback", 8'(v & 8'h1F));
    end
    wr(0, 8'hFF);

    // R6 and R11 byte register sweeps
    for (int v = 0; v < 256; v++) begin
      wr(4, 8'(v));
      chk("R6 read flag", 16'(seq_read), 16'(v & 1));
      chk("R6 target", 16'(seq_target), 16'(v >> 1));
      rd(4, "R11 target readback", 8'(v));
      wr(3, 8'(v ^ 8'h5A));
      chk("R11 seq_cmd", 16'(seq_cmd), 16'(v ^ 8'h5A));
      rd(3, "R11 cmd readback", 8'(v ^ 8'h5A));
      wr(5, 8'(v + 1));
      rd(5, "R11 data0 readback", 8'(v + 1));
      wr(6, 8'(v * 3));
      chk("R11 seq_data0", 16'(seq_data0), 16'((v + 1) & 255));
      rd(6, "R11 data1 readback", 8'(v * 3));
    end

    // R7 block buffer with wrap; index starts at 0 after status write
    wr(0, 8'h00);
    for (int i = 0; i < 40; i++) begin
      wr(7, 8'(i * 7 + 3));
      img[i % DEPTH] = 8'(i * 7 + 3);
    end
    wr(0, 8'h00);
    for (int i = 0; i < 2 * DEPTH; i++) rd(7, "R7 block read wrap", img[i % DEPTH]);
    // R3 and R5 index resets
    rd(7, "R7 idx0", img[0]);
    rd(7, "R7 idx1", img[1]);
    wr(0, 8'h00);
    rd(7, "R3 index reset", img[0]);
    rd(2, "R5 ctl read", 8'h1F);
    rd(7, "R5 index reset", img[0]);
    // R12 sequencer buffer port
    for (int i = 0; i < DEPTH; i++) begin
      seq_buf_addr = 5'(i);
      #1 chk("R12 seq buf read", 16'(seq_buf_rdata), 16'(img[i]));
    end
    seq_buf_addr = 5'd9; seq_buf_wdata = 8'hC3; seq_buf_we = 1;
    @(posedge clk); @(negedge clk);
    seq_buf_we = 0;
    chk("R12 seq buf write", 16'(seq_buf_rdata), 16'hC3);
    wr(0, 8'h00);
    for (int i = 0; i < 9; i++) rd(7, "R12 skip", img[i]);
    rd(7, "R12 host sees seq write", 8'hC3);

    // R2 unmapped offsets
    wr(3, 8'h11); wr(4, 8'h22); wr(5, 8'h33); wr(6, 8'h44); wr(2, 8'h0C); wr(0, 8'hFF);
    for (int a = 1; a < 64; a++) begin
      if (a == 1 || a > 7) begin
        wr(a, 8'hFF);
        rd(a, "R2 unmapped read", 8'h00);
      end
    end
    rd(0, "R2 status kept", 8'h00);
    rd(2, "R2 ctl kept", 8'h0C);
    rd(3, "R2 cmd kept", 8'h11);
    rd(4, "R2 tgt kept", 8'h22);
    rd(5, "R2 d0 kept", 8'h33);
    rd(6, "R2 d1 kept", 8'h44);
    wr(0, 8'h00);
    rd(7, "R2 buf kept", img[0]);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule